// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Packet Fabric

This block moves fixed-size packets from N source lanes to N sink lanes, where N is a power of two. It is built from log2(N) columns of two-by-two steering cells. Perfect-shuffle wiring sits in front of every column. No central route computation exists. Each cell looks only at one bit of a packet's destination field and sends the packet to its upper or lower exit. Because each source and sink pair has a single path, two packets can need the same internal link in the same cycle. The cell then lets one through and discards the other. It reports the discard as a per-source flag so the sender can act on it.

Every column has one register. A packet that survives reaches its sink lane a fixed number of cycles after it was accepted. Conflict-free patterns pass intact, with every packet delivered every cycle. Such patterns include the identity mapping and the cyclic shifts of the lane index. Colliding patterns lose packets, and the per-stage discard vector names exactly which sources lost theirs.

Top module: `omega_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `drop_mask` are all zero.
- R2: A packet sampled on input lane s at a rising edge, and not discarded, shows on the output ports exactly LOG_N rising edges later.
- R3: A delivered packet appears on the output lane whose index equals its destination field. Its destination and payload are unchanged.
- R4: Any pattern where destination = (source + c) mod N, including c = 0, delivers all N packets and discards none.
- R5: Stage k (k = 0 nearest the inputs) steers by destination bit LOG_N-1-k. A 0 selects the upper exit (even line) and a 1 the lower exit (odd line). The shuffle in front of each stage moves line j to the line given by rotating j's LOG_N-bit index left by one. When both packets in a cell want the same exit, one is discarded. Then bit k*N+s of `drop_mask` is 1 in the same cycle the survivor occupies stage k's register, where s is the discarded packet's original input lane.
- R6: Each cell holds its own round-robin pointer. After reset the pointer favours the cell's upper input line. After each conflict it moves to favour the other input. Cells with no conflict keep their pointer.
- R7: With N = 8, packets sent in the same cycle from lane 1 to sink 6 and from lane 3 to sink 7 collide at stage 1. On the first such collision after reset, lane 3 is discarded (bit 11). On the next one, lane 1 is discarded (bit 9).
- R8: Over any run, the number of valid packets accepted equals the packets delivered plus the packets discarded plus the packets still inside the stage registers.
- R9: Destination and payload on a lane whose `in_valid` is low have no effect: nothing is delivered and nothing is discarded for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Packet present on each source lane |
| in_dest | input | N*LOG_N | Destination field per lane, lane s at bits s*LOG_N upward |
| in_data | input | N*W | Payload per lane, lane s at bits s*W upward |
| out_valid | output | N | Packet present on each sink lane |
| out_dest | output | N*LOG_N | Destination field carried with each delivered packet |
| out_data | output | N*W | Payload of each delivered packet |
| drop_mask | output | LOG_N*N | Bit k*N+s set when a packet from source s was discarded at stage k |

## Verification
The pipeline lets a delivery and discards land in the same cycle. A packet from an earlier vector leaves the last stage while packets of later vectors are discarded in the stages nearer the inputs. The stimulus provokes this by sending colliding vectors back to back, without idle cycles. These include all-to-one patterns and random traffic. A scoreboard model predicts, for each cycle, both the sink-lane contents and the full discard vector, and compares them together. The conservation property ties the two counts to the injected count edge by edge, so a packet that is both delivered and flagged, or neither, is caught.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Line index after the perfect shuffle: rotate a lg-bit index left by one.
  function automatic int unsigned shuffle_line(int unsigned line, int unsigned lg);
    if (lg <= 1) return line;
    return ((line << 1) | (line >> (lg - 1))) & ((1 << lg) - 1);
  endfunction

  // Destination bit that steers a given stage, most significant first.
  function automatic int unsigned steer_bit(int unsigned stage, int unsigned lg);
    return lg - 1 - stage;
  endfunction

endpackage

// File: rtl/omega_cell.sv
module omega_cell #(
  parameter int LOG_N   = 3,
  parameter int W       = 8,
  parameter int SEL_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           in_v,
  input  logic [2*LOG_N-1:0]   in_dest,
  input  logic [2*W-1:0]       in_data,
  input  logic [2*LOG_N-1:0]   in_src,
  output logic [1:0]           out_v,
  output logic [2*LOG_N-1:0]   out_dest,
  output logic [2*W-1:0]       out_data,
  output logic [2*LOG_N-1:0]   out_src,
  output logic [1:0]           drop,
  output logic                 ev_conflict,
  output logic                 ev_win_lower
);

  logic [1:0] want;
  logic       ptr;

  assign want[0]      = in_dest[SEL_BIT];
  assign want[1]      = in_dest[LOG_N + SEL_BIT];
  assign ev_conflict  = in_v[0] & in_v[1] & (want[0] == want[1]);
  assign ev_win_lower = ptr;

  always_comb begin
    out_v    = '0;
    out_dest = '0;
    out_data = '0;
    out_src  = '0;
    drop     = '0;
    for (int i = 0; i < 2; i++) begin
      if (in_v[i]) begin
        if (ev_conflict && (i != int'(ptr))) begin
          drop[i] = 1'b1;
        end else begin
          out_v[want[i]]                      = 1'b1;
          out_dest[want[i]*LOG_N +: LOG_N]    = in_dest[i*LOG_N +: LOG_N];
          out_data[want[i]*W +: W]            = in_data[i*W +: W];
          out_src[want[i]*LOG_N +: LOG_N]     = in_src[i*LOG_N +: LOG_N];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ptr <= 1'b0;
    else if (ev_conflict) ptr <= ~ptr;
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int LOG_N = 3,
  parameter int W     = 8,
  parameter int STAGE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<LOG_N)-1:0]  d_v,
  input  logic [(1<<LOG_N)*LOG_N-1:0] d_dest,
  input  logic [(1<<LOG_N)*W-1:0]     d_data,
  input  logic [(1<<LOG_N)*LOG_N-1:0] d_src,
  output logic [(1<<LOG_N)-1:0]  q_v,
  output logic [(1<<LOG_N)*LOG_N-1:0] q_dest,
  output logic [(1<<LOG_N)*W-1:0]     q_data,
  output logic [(1<<LOG_N)*LOG_N-1:0] q_src,
  output logic [(1<<LOG_N)-1:0]  q_drop,
  output logic [(1<<LOG_N)/2-1:0] ev_conflict,
  output logic [(1<<LOG_N)/2-1:0] ev_win_lower
);

  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;
  localparam int SEL  = int'(omega_pkg::steer_bit(STAGE, LOG_N));

  logic [N-1:0]       sh_v;
  logic [N*LOG_N-1:0] sh_dest;
  logic [N*W-1:0]     sh_data;
  logic [N*LOG_N-1:0] sh_src;

  logic [N-1:0]       nx_v;
  logic [N*LOG_N-1:0] nx_dest;
  logic [N*W-1:0]     nx_data;
  logic [N*LOG_N-1:0] nx_src;
  logic [N-1:0]       side_drop;
  logic [N-1:0]       nx_drop;

  for (genvar j = 0; j < N; j++) begin : g_shuffle
    localparam int TO = int'(omega_pkg::shuffle_line(j, LOG_N));
    assign sh_v[TO]                      = d_v[j];
    assign sh_dest[TO*LOG_N +: LOG_N]    = d_dest[j*LOG_N +: LOG_N];
    assign sh_data[TO*W +: W]            = d_data[j*W +: W];
    assign sh_src[TO*LOG_N +: LOG_N]     = d_src[j*LOG_N +: LOG_N];
  end

  for (genvar e = 0; e < HALF; e++) begin : g_cell
    omega_cell #(.LOG_N(LOG_N), .W(W), .SEL_BIT(SEL)) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_v         (sh_v[2*e +: 2]),
      .in_dest      (sh_dest[2*e*LOG_N +: 2*LOG_N]),
      .in_data      (sh_data[2*e*W +: 2*W]),
      .in_src       (sh_src[2*e*LOG_N +: 2*LOG_N]),
      .out_v        (nx_v[2*e +: 2]),
      .out_dest     (nx_dest[2*e*LOG_N +: 2*LOG_N]),
      .out_data     (nx_data[2*e*W +: 2*W]),
      .out_src      (nx_src[2*e*LOG_N +: 2*LOG_N]),
      .drop         (side_drop[2*e +: 2]),
      .ev_conflict  (ev_conflict[e]),
      .ev_win_lower (ev_win_lower[e])
    );
  end

  // Translate a discard on a line into the source lane it came from.
  always_comb begin
    nx_drop = '0;
    for (int l = 0; l < N; l++) begin
      if (side_drop[l]) nx_drop[sh_src[l*LOG_N +: LOG_N]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v    <= '0;
      q_dest <= '0;
      q_data <= '0;
      q_src  <= '0;
      q_drop <= '0;
    end else begin
      q_v    <= nx_v;
      q_dest <= nx_dest;
      q_data <= nx_data;
      q_src  <= nx_src;
      q_drop <= nx_drop;
    end
  end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<LOG_N)-1:0]         in_valid,
  input  logic [(1<<LOG_N)*LOG_N-1:0]   in_dest,
  input  logic [(1<<LOG_N)*W-1:0]       in_data,
  output logic [(1<<LOG_N)-1:0]         out_valid,
  output logic [(1<<LOG_N)*LOG_N-1:0]   out_dest,
  output logic [(1<<LOG_N)*W-1:0]       out_data,
  output logic [LOG_N*(1<<LOG_N)-1:0]   drop_mask
);

  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;

  logic [N-1:0]       v_chain    [LOG_N+1];
  logic [N*LOG_N-1:0] dest_chain [LOG_N+1];
  logic [N*W-1:0]     data_chain [LOG_N+1];
  logic [N*LOG_N-1:0] src_chain  [LOG_N+1];

  // Observation wires for the bound checker.
  logic [LOG_N*N-1:0]    stg_valid_all;
  logic [LOG_N*HALF-1:0] conflict_all;
  logic [LOG_N*HALF-1:0] win_lower_all;

  assign v_chain[0]    = in_valid;
  assign dest_chain[0] = in_dest;
  assign data_chain[0] = in_data;

  for (genvar j = 0; j < N; j++) begin : g_src_tag
    assign src_chain[0][j*LOG_N +: LOG_N] = LOG_N'(j);
  end

  for (genvar s = 0; s < LOG_N; s++) begin : g_stage
    omega_stage #(.LOG_N(LOG_N), .W(W), .STAGE(s)) u_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .d_v          (v_chain[s]),
      .d_dest       (dest_chain[s]),
      .d_data       (data_chain[s]),
      .d_src        (src_chain[s]),
      .q_v          (v_chain[s+1]),
      .q_dest       (dest_chain[s+1]),
      .q_data       (data_chain[s+1]),
      .q_src        (src_chain[s+1]),
      .q_drop       (drop_mask[s*N +: N]),
      .ev_conflict  (conflict_all[s*HALF +: HALF]),
      .ev_win_lower (win_lower_all[s*HALF +: HALF])
    );
    assign stg_valid_all[s*N +: N] = v_chain[s+1];
  end

  assign out_valid = v_chain[LOG_N];
  assign out_dest  = dest_chain[LOG_N];
  assign out_data  = data_chain[LOG_N];

endmodule

// File: rtl/omega_checker.sv
module omega_checker #(
  parameter int LOG_N = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(1<<LOG_N)-1:0]       in_valid,
  input logic [(1<<LOG_N)-1:0]       out_valid,
  input logic [(1<<LOG_N)*LOG_N-1:0] out_dest,
  input logic [LOG_N*(1<<LOG_N)-1:0] drop_mask,
  input logic [LOG_N*(1<<LOG_N)-1:0] stg_valid_all,
  input logic [LOG_N*(1<<LOG_N)/2-1:0] conflict_all,
  input logic [LOG_N*(1<<LOG_N)/2-1:0] win_lower_all
);

  localparam int N      = 1 << LOG_N;
  localparam int TOT    = LOG_N * N;
  localparam int CELLS  = LOG_N * N / 2;
  localparam logic [TOT-1:0] INNER_MASK = {TOT{1'b1}} >> N;

  logic [TOT-1:0]   inner_valid;
  logic [CELLS-1:0] last_win_lower;

  assign inner_valid = stg_valid_all & INNER_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_win_lower <= '1;
    else begin
      for (int i = 0; i < CELLS; i++)
        if (conflict_all[i]) last_win_lower[i] <= win_lower_all[i];
    end
  end

  // R1: nothing leaves the fabric right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0 && drop_mask == '0));

  // R8: per edge, packets in plus packets moving inward equal packets held plus discards
  a_r8_conservation: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      ($countones(stg_valid_all) + $countones(drop_mask) ==
       $past($countones(in_valid)) + $past($countones(inner_valid))));

  // R9: an idle input cycle puts nothing into the first stage
  a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) == '0) |->
      (stg_valid_all[N-1:0] == '0 && drop_mask[N-1:0] == '0));

  for (genvar j = 0; j < N; j++) begin : g_lane
    // R3: a delivered packet sits on the lane its destination names
    a_r3_right_lane: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (out_dest[j*LOG_N +: LOG_N] == LOG_N'(j)));

    // R5: a first-stage discard names a source that really sent a packet
    a_r5_drop_had_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && drop_mask[j]) |-> $past(in_valid[j]));
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell_rr
    // R6: successive conflicts in one cell alternate the winning side
    a_r6_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_all[c] |-> (win_lower_all[c] != last_win_lower[c]));
  end

endmodule

bind omega_fabric omega_checker #(.LOG_N(LOG_N)) u_omega_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_dest      (out_dest),
  .drop_mask     (drop_mask),
  .stg_valid_all (stg_valid_all),
  .conflict_all  (conflict_all),
  .win_lower_all (win_lower_all)
);

// File: tb/test_omega_fabric.sv
`timescale 1ns/1ps
module test_omega_fabric;

  localparam int LG = 3;
  localparam int N  = 1 << LG;
  localparam int W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*LG-1:0]   in_dest = '0;
  logic [N*W-1:0]    in_data = '0;
  logic [N-1:0]      out_valid;
  logic [N*LG-1:0]   out_dest;
  logic [N*W-1:0]    out_data;
  logic [LG*N-1:0]   drop_mask;

  omega_fabric #(.LOG_N(LG), .W(W)) i_omega_fabric (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_dest(out_dest),
    .out_data(out_data), .drop_mask(drop_mask)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         cyc;
    bit         is_drop;
    int         idx;
    logic [W-1:0] data;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   errs = 0;
  int   checks = 0;
  int   n_inj = 0, n_del = 0, n_drp = 0;
  bit   mon_on = 0;
  bit   done = 0;

  bit           sv [N];
  int           sd [N];
  logic [W-1:0] sx [N];
  bit           mptr [LG][N/2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int dbit(int d, int k);
    return (d >> (LG - 1 - k)) & 1;
  endfunction

  // Reference model: walks every packet through the columns using R5 and R6.
  task automatic model(int t);
    int  line [N];
    int  pre  [N];
    bit  alive [N];
    for (int s = 0; s < N; s++) begin
      alive[s] = sv[s];
      line[s]  = s;
      if (sv[s]) n_inj++;
    end
    for (int k = 0; k < LG; k++) begin
      for (int s = 0; s < N; s++) pre[s] = (line[s] * 2) % N + line[s] / (N / 2);
      for (int e = 0; e < N / 2; e++) begin
        int up = -1;
        int lo = -1;
        for (int s = 0; s < N; s++)
          if (alive[s] && pre[s] / 2 == e) begin
            if (pre[s] % 2 == 0) up = s; else lo = s;
          end
        if (up >= 0 && lo >= 0 && dbit(sd[up], k) == dbit(sd[lo], k)) begin
          int loser = mptr[k][e] ? up : lo;
          exp_q.push_back('{t + k + 1, 1'b1, k * N + loser, '0});
          alive[loser] = 0;
          mptr[k][e] = ~mptr[k][e];
        end
      end
      for (int s = 0; s < N; s++) line[s] = (pre[s] / 2) * 2 + dbit(sd[s], k);
    end
    for (int s = 0; s < N; s++)
      if (alive[s]) exp_q.push_back('{t + LG, 1'b0, sd[s], sx[s]});
  endtask

  task automatic apply();
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      in_valid[s]           = sv[s];
      in_dest[s*LG +: LG]   = LG'(sd[s]);
      in_data[s*W +: W]     = sx[s];
    end
    model(cyc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < N; s++) sv[s] = 0;
      apply();
    end
  endtask

  // Scoreboard monitor: compares lanes and discard vector every cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      logic [N-1:0]    ev;
      logic [LG*N-1:0] ed;
      logic [W-1:0]    edat [N];
      ev = '0; ed = '0;
      for (int s = 0; s < N; s++) edat[s] = '0;
      for (int qi = exp_q.size() - 1; qi >= 0; qi--) begin
        if (exp_q[qi].cyc == cyc) begin
          if (exp_q[qi].is_drop) ed[exp_q[qi].idx] = 1'b1;
          else begin
            ev[exp_q[qi].idx]   = 1'b1;
            edat[exp_q[qi].idx] = exp_q[qi].data;
          end
          exp_q.delete(qi);
        end
      end
      chk(out_valid == ev, "R2 R3 lane occupancy", out_valid, ev);
      for (int s = 0; s < N; s++)
        if (ev[s] && out_valid[s]) begin
          chk(out_data[s*W +: W] == edat[s], "R3 payload", out_data[s*W +: W], edat[s]);
          chk(out_dest[s*LG +: LG] == LG'(s), "R3 dest field", out_dest[s*LG +: LG], s);
        end
      chk(drop_mask == ed, "R5 R6 discard vector", drop_mask, ed);
      n_del += $countones(out_valid);
      n_drp += $countones(drop_mask);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int d0, dl0, t0;
    for (int k = 0; k < LG; k++)
      for (int e = 0; e < N / 2; e++) mptr[k][e] = 0;
    for (int s = 0; s < N; s++) begin sv[s] = 0; sd[s] = 0; sx[s] = '0; end

    repeat (3) @(negedge clk);
    chk(out_valid == '0 && drop_mask == '0, "R1 during reset", {out_valid, drop_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && drop_mask == '0, "R1 after release", {out_valid, drop_mask}, 0);
    mon_on = 1;

    // R4: identity and every cyclic shift, back to back
    d0 = n_drp; dl0 = n_del;
    for (int c = 0; c < N; c++) begin
      for (int s = 0; s < N; s++) begin
        sv[s] = 1; sd[s] = (s + c) % N; sx[s] = W'(s * 17 + c * 5 + 1);
      end
      apply();
    end
    idle(LG + 1);
    chk(n_drp == d0, "R4 no discards on shifts", n_drp - d0, 0);
    chk(n_del - dl0 == N * N, "R4 all delivered", n_del - dl0, N * N);

    // R7 and R6: the blocking pair twice
    for (int s = 0; s < N; s++) sv[s] = 0;
    sv[1] = 1; sd[1] = 6; sx[1] = 8'hA1;
    sv[3] = 1; sd[3] = 7; sx[3] = 8'hB3;
    apply();
    t0 = cyc;
    idle(2);
    chk(drop_mask == (1 << (N + 3)), "R7 lane 3 discarded at stage 1", drop_mask, 1 << (N + 3));
    idle(1);
    chk(out_valid == 8'h40 && out_data[6*W +: W] == 8'hA1, "R2 R7 survivor latency",
        {out_valid, out_data[6*W +: W]}, {8'h40, 8'hA1});
    chk(cyc == t0 + LG, "R2 latency count", cyc - t0, LG);
    idle(2);
    for (int s = 0; s < N; s++) sv[s] = 0;
    sv[1] = 1; sd[1] = 6; sx[1] = 8'hC1;
    sv[3] = 1; sd[3] = 7; sx[3] = 8'hD3;
    apply();
    idle(2);
    chk(drop_mask == (1 << (N + 1)), "R6 pointer moved, lane 1 discarded", drop_mask, 1 << (N + 1));
    idle(LG);

    // R5: everyone aims at sink 0, back to back, discards at several stages
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < N; s++) begin sv[s] = 1; sd[s] = 0; sx[s] = W'(s + r * 16); end
      apply();
    end
    idle(LG + 1);

    // R9: garbage on idle lanes
    dl0 = n_del; d0 = n_drp;
    for (int r = 0; r < 6; r++) begin
      for (int s = 0; s < N; s++) sv[s] = 0;
      apply();
      for (int s = 0; s < N; s++) begin
        in_dest[s*LG +: LG] = LG'($urandom);
        in_data[s*W +: W]   = W'($urandom);
      end
    end
    idle(LG + 1);
    chk(n_del == dl0 && n_drp == d0, "R9 invalid lanes inert", n_del - dl0 + n_drp - d0, 0);

    // Mixed random traffic, pipelined: deliveries and discards share cycles
    for (int r = 0; r < 300; r++) begin
      for (int s = 0; s < N; s++) begin
        sv[s] = ($urandom % 4) != 0; sd[s] = $urandom % N; sx[s] = W'($urandom);
      end
      apply();
    end
    idle(LG + 2);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    chk(n_inj == n_del + n_drp, "R8 conservation", n_del + n_drp, n_inj);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule